// File: doc/BRIEF.md
# D-Channel Bit-Pair Byte Assembler

The block packs a framed serial D channel into parallel bytes and unpacks parallel bytes back onto the line. Each frame carries two D bits. The block samples them on two consecutive data-clock cycles at a configurable offset after the frame sync. Four frames in a row give one 8-bit receive byte, and the block then raises a one-cycle valid strobe. The transmit side drives its two bits per frame in the same slots. It takes a new parallel byte at the first slot of every four-frame group.

A mode input selects the bit order. In HDLC-encoded mode the line carries the least significant bit first and bytes are right-aligned. In unencoded mode the line carries the most significant bit first and bytes are left-aligned. Two events restart the byte at frame 0: a frame sync that arrives after only one bit of a pair has been taken, and a change of mode.

Top module: `dch_pair_packer`

## Requirements
- R1: After reset, rx_byte is 0x00 and rx_valid, tx_take are 0. tx_bit stays 1 until the first frame sync.
- R2: The cycle with fsync high is position 0 of a frame. The two D bits are sampled on rx_bit at positions slot_ofs and slot_ofs+1. An offset of 0 samples in the fsync cycle itself.
- R3: With hdlc_mode=1, the k-th D bit of a group (k=0..7, in line order) lands in rx_byte bit k. The pair from frame n therefore occupies bits 2n+1:2n.
- R4: With hdlc_mode=0, the k-th D bit of a group lands in rx_byte bit 7-k. The pair from frame n therefore occupies bits 7-2n:6-2n.
- R5: rx_valid is high for exactly one cycle. That cycle is the one after the edge that samples the eighth bit of a group. rx_byte holds the assembled byte until the next one completes.
- R6: A fsync that arrives after the first bit of a pair and before the second drops the partial pair. It also drops the group, and that frame counts as frame 0 of a new group.
- R7: Any change of hdlc_mode drops the group in progress. The next pair taken is frame 0 of a new group.
- R8: In each D slot, tx_bit carries the k-th bit of the group's transmit byte, in the same order as R3 (hdlc_mode=1) or R4 (hdlc_mode=0). Outside D slots tx_bit is 1.
- R9: In the first slot of each group, the byte for that group is latched. If tx_avail is 1, the byte is tx_byte and tx_take is 1 in that cycle. If tx_avail is 0, the byte is 0xFF and tx_take stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, high for the first bit cycle of a frame |
| rx_bit | input | 1 | Serial receive data |
| hdlc_mode | input | 1 | 1: lsb first, right-aligned; 0: msb first, left-aligned |
| slot_ofs | input | OFS_W | Position of the first D bit after fsync |
| tx_byte | input | 8 | Parallel byte to transmit |
| tx_avail | input | 1 | tx_byte holds a new byte |
| rx_byte | output | 8 | Last assembled receive byte |
| rx_valid | output | 1 | One-cycle strobe, rx_byte updated |
| tx_bit | output | 1 | Serial transmit data |
| tx_take | output | 1 | tx_byte taken this cycle |

## Verification
Random bytes are sent in both modes at random slot offsets, while the bits outside the D slots are random noise. Bytes that are not symmetric under bit reversal show whether the order and alignment follow R3 or R4. The noise shows whether the sampling positions are right. Directed cases cover these situations:
- an offset of zero, where the first bit falls in the sync cycle;
- a late offset;
- a frame cut short after one bit of a pair;
- a mode switch in the middle of a group;
- groups with no transmit byte, where the 0xFF idle byte tells a stale load apart from a correct one.

// File: rtl/dch_pair_packer.sv
module dch_pair_packer #(
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             rx_bit,
  input  logic             hdlc_mode,
  input  logic [OFS_W-1:0] slot_ofs,
  input  logic [7:0]       tx_byte,
  input  logic             tx_avail,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  output logic             tx_bit,
  output logic             tx_take
);

  localparam int PW = OFS_W + 1;
  localparam logic [PW-1:0] POS_MAX = '1;

  logic [PW-1:0] pos_q, pos_c, slot_a, slot_b;
  logic          synced_q, mode_q;
  logic [2:0]    cnt_q, cnt_eff;
  logic [7:0]    sh_q, sh_n, tx_hold, tx_cur;
  logic          restart, live, hit_a, hit_b, samp;

  assign pos_c   = fsync ? '0 : pos_q;
  assign slot_a  = {1'b0, slot_ofs};
  assign slot_b  = slot_a + 1'b1;
  assign live    = synced_q | fsync;
  assign restart = (hdlc_mode != mode_q) | (fsync & cnt_q[0]);
  assign cnt_eff = restart ? 3'd0 : cnt_q;
  assign hit_a   = live && (pos_c == slot_a) && !cnt_eff[0];
  assign hit_b   = live && (pos_c == slot_b) && cnt_eff[0];
  assign samp    = hit_a | hit_b;
  assign sh_n    = hdlc_mode ? {rx_bit, sh_q[7:1]} : {sh_q[6:0], rx_bit};
  assign tx_cur  = (cnt_eff == 3'd0) ? (tx_avail ? tx_byte : 8'hFF) : tx_hold;
  assign tx_bit  = samp ? (hdlc_mode ? tx_cur[cnt_eff] : tx_cur[3'd7 - cnt_eff]) : 1'b1;
  assign tx_take = samp && (cnt_eff == 3'd0) && tx_avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      synced_q <= 1'b0;
      mode_q   <= 1'b1;
      cnt_q    <= 3'd0;
      sh_q     <= 8'h00;
      tx_hold  <= 8'hFF;
      rx_byte  <= 8'h00;
      rx_valid <= 1'b0;
    end else begin
      pos_q    <= (pos_c == POS_MAX) ? pos_c : pos_c + 1'b1;
      synced_q <= live;
      mode_q   <= hdlc_mode;
      rx_valid <= samp && (cnt_eff == 3'd7);
      if (samp) begin
        sh_q  <= sh_n;
        cnt_q <= cnt_eff + 3'd1;
        if (cnt_eff == 3'd7) rx_byte <= sh_n;
        if (cnt_eff == 3'd0) tx_hold <= tx_cur;
      end else begin
        cnt_q <= cnt_eff;
      end
    end
  end

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_valid_group_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (cnt_q == 3'd0));

  assert_half_pair_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && cnt_q[0]) |=> (cnt_q <= 3'd1));

  assert_mode_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdlc_mode != mode_q) |=> (cnt_q <= 3'd1));

  assert_take_first_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> (cnt_q == 3'd1));

endmodule

// File: tb/tb_dch_pair_packer.sv
module tb_dch_pair_packer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0, rx_bit = 1'b0, hdlc_mode = 1'b1, tx_avail = 1'b0;
  logic [4:0] slot_ofs = 5'd0;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic rx_valid, tx_bit, tx_take;

  int vectors = 0, fails = 0;
  int vcnt, takes, idle_bad;
  logic [7:0] vbyte;
  logic [7:0] txl;

  always #2 clk = ~clk;

  dch_pair_packer dut (.clk(clk), .rst_n(rst_n), .fsync(fsync), .rx_bit(rx_bit),
    .hdlc_mode(hdlc_mode), .slot_ofs(slot_ofs), .tx_byte(tx_byte), .tx_avail(tx_avail),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_bit(tx_bit), .tx_take(tx_take));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic line_bit(input logic [7:0] b, input int k, input logic m);
    return m ? b[k] : b[7-k];
  endfunction

  task automatic cycle(input logic fs, input logic b, input int slot_k);
    @(negedge clk);
    if (rx_valid) begin vcnt++; vbyte = rx_byte; end
    fsync = fs; rx_bit = b;
    #1;
    if (slot_k >= 0) txl[slot_k] = tx_bit;
    else if (tx_bit !== 1'b1) idle_bad++;
    if (tx_take) takes++;
  endtask

  task automatic frame(input logic b0, input logic b1, input int f, input int flen);
    for (int p = 0; p < flen; p++) begin
      if (p == slot_ofs)          cycle(p == 0, b0, 2*f);
      else if (p == slot_ofs + 1) cycle(p == 0, b1, 2*f + 1);
      else                        cycle(p == 0, 1'($urandom % 2), -1);
    end
  endtask

  task automatic xfer(input logic [7:0] rxv, input logic [7:0] txv, input logic avail, input string tag);
    logic [7:0] exp_tx;
    tx_byte = txv; tx_avail = avail;
    vcnt = 0; takes = 0; idle_bad = 0; txl = 8'h00;
    exp_tx = avail ? txv : 8'hFF;
    for (int f = 0; f < 4; f++)
      frame(line_bit(rxv, 2*f, hdlc_mode), line_bit(rxv, 2*f+1, hdlc_mode), f, 16);
    chk(vcnt == 1, {"R5 valid pulses ", tag}, vcnt, 1);
    chk(vbyte == rxv, hdlc_mode ? {"R3 rx_byte ", tag} : {"R4 rx_byte ", tag}, vbyte, rxv);
    for (int k = 0; k < 8; k++)
      if (txl[k] !== line_bit(exp_tx, k, hdlc_mode)) begin
        chk(1'b0, {"R8 tx bit order ", tag}, txl, exp_tx);
        break;
      end
    chk(idle_bad == 0, {"R8 idle high ", tag}, idle_bad, 0);
    chk(takes == int'(avail), {"R9 take count ", tag}, takes, int'(avail));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    #1;
    chk(rx_byte == 8'h00, "R1 rx_byte reset", rx_byte, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid reset", rx_valid, 0);
    chk(tx_bit == 1'b1 && tx_take == 1'b0, "R1 tx idle reset", {tx_bit, tx_take}, 2);
    rst_n = 1'b1;
    repeat (5) cycle(1'b0, 1'b0, -1);
    chk(tx_bit == 1'b1 && rx_valid == 1'b0, "R1 idle before sync", {tx_bit, rx_valid}, 2);

    slot_ofs = 5'd0; hdlc_mode = 1'b1;
    xfer(8'h1E, 8'hC5, 1'b1, "R2 ofs0 hdlc");
    hdlc_mode = 1'b0;
    xfer(8'h1E, 8'hC5, 1'b1, "R2 ofs0 unenc");
    slot_ofs = 5'd13;
    xfer(8'h81, 8'h3A, 1'b0, "R2 late ofs");
    hdlc_mode = 1'b1;
    xfer(8'h0F, 8'h55, 1'b0, "R9 idle ff hdlc");

    slot_ofs = 5'd4;
    frame(1'b1, 1'b0, 0, 16);
    frame(1'b0, 1'b1, 1, 16);
    frame(1'b1, 1'b1, 2, 5);
    xfer(8'hB2, 8'h6D, 1'b1, "R6 half pair restart");

    frame(1'b1, 1'b1, 0, 16);
    frame(1'b0, 1'b1, 1, 16);
    hdlc_mode = 1'b0;
    xfer(8'hB2, 8'h6D, 1'b1, "R7 mode change");
    frame(1'b1, 1'b0, 0, 16);
    hdlc_mode = 1'b1;
    xfer(8'h47, 8'h91, 1'b1, "R7 mode change back");

    for (int i = 0; i < 40; i++) begin
      slot_ofs = 5'($urandom % 14);
      hdlc_mode = 1'($urandom % 2);
      xfer(8'($urandom), 8'($urandom), 1'($urandom % 4 != 0), "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule